// File: doc/BRIEF.md
# Circular Sampling Memory Controller

This block sequences a ring of sampling cells that keeps recording the most recent slice of a signal. After it is armed, exactly one cell is write-enabled at a time. The enabled position moves forward by one cell on each sampling tick and returns to cell 0 after the last cell, so the ring always holds the latest history.

When a trigger arrives, writing stops and the controller stores the position that was enabled at that moment. It then reads out a window of cells. By default the window starts a programmable number of cells before the stored position, which compensates for trigger latency, and it runs for a programmable number of cells. In full mode it reads every cell in the ring, oldest sample first. Each read presents a cell index with a valid flag and waits for an acknowledge. Only the requested cells are visited, which keeps dead time short. After the last cell the controller pulses a done flag and resumes sampling.

The analog cells and the converter are outside this block. They appear only as the write-enable vector and the read-cell index.

Top module: `circ_capture_ctrl`

## Requirements
- R1: After reset the controller is idle. `writeEn` is all zero, `rdValid` and `doneOut` are low, and `trigCell` is 0.
- R2: `armIn` while idle starts sampling at cell 0. While sampling, `writeEn` has exactly one bit set: bit k means cell k is enabled. In every other state it is all zero.
- R3: Each cycle with `sampleTick` high while sampling moves the enabled cell forward by one, modulo NUM_CELLS. After cell NUM_CELLS-1 the next enabled cell is 0.
- R4: `trigIn` while sampling stores the currently enabled cell in `trigCell`, and `writeEn` is zero from the next cycle. If a trigger and a tick arrive in the same cycle, the trigger wins and the position does not move.
- R5: `trigIn` outside sampling is ignored: `trigCell` keeps its value and no readout starts. `sampleTick` outside sampling does not move the write position.
- R6: In window mode (`fullMode` low) the first cell read is `trigCell` minus (`winOffset` mod NUM_CELLS), taken modulo NUM_CELLS. The window length is `winLength`, where 0 counts as 1 and values above NUM_CELLS count as NUM_CELLS. Mode, offset and length are captured in the trigger cycle.
- R7: In full mode (`fullMode` high) exactly NUM_CELLS cells are read. The first is `trigCell`+1 modulo NUM_CELLS and the last is `trigCell`. The offset is ignored.
- R8: `rdValid` rises in the second cycle after the trigger is accepted. `rdCell` holds its value until `readAck` is seen with `rdValid` high. The next index, one higher modulo NUM_CELLS, is presented in the following cycle.
- R9: After the last cell is acknowledged, `rdValid` falls and `doneOut` is high for exactly one cycle. Sampling then resumes, with the enabled cell equal to `trigCell`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armIn | input | 1 | Start sampling from idle |
| sampleTick | input | 1 | Advance the write position by one cell |
| trigIn | input | 1 | Trigger: stop writing and read out |
| fullMode | input | 1 | 1 = read the whole ring, 0 = read a window |
| winOffset | input | IDX_W | Cells to step back from the trigger cell |
| winLength | input | CNT_W | Number of cells in the window |
| readAck | input | 1 | Consumer has taken the presented cell |
| writeEn | output | NUM_CELLS | One-hot write enable for the cells |
| rdValid | output | 1 | `rdCell` holds a cell to read |
| rdCell | output | IDX_W | Index of the cell being read |
| trigCell | output | IDX_W | Cell that was enabled at the trigger |
| doneOut | output | 1 | One-cycle pulse when readout ends |

## Verification
The bench builds the block with NUM_CELLS set to 12. Because that is not a power of two, every wrap needs an explicit compare against the last cell, and plain binary overflow would give wrong indices. The 4-bit offset and length inputs can also carry values from 12 to 15, which exercises the offset reduction and the length clamp. A window that crosses cell 11, a full ring, a single-cell window and a clamped length all fit in a few hundred cycles. The consumer stalls on some cycles, so both held and advancing read indices occur.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLING,
    ST_FROZEN,
    ST_READOUT,
    ST_REARM
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advWrite;   // move write position forward
    logic loadTrig;   // capture trigger cell and readout config
    logic loadStart;  // compute first read cell
    logic advRead;    // move read index forward
  } dp_strobe_t;

endpackage

// File: rtl/ccm_datapath.sv
module ccm_datapath
  import ccm_pkg::*;
#(
  parameter int NUM_CELLS = 16,
  parameter int IDX_W     = $clog2(NUM_CELLS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_strobe_t           strobe,
  input  logic                 sampling,
  input  logic                 fullMode,
  input  logic [IDX_W-1:0]     winOffset,
  output logic [NUM_CELLS-1:0] writeEn,
  output logic [IDX_W-1:0]     writePos,
  output logic [IDX_W-1:0]     trigCell,
  output logic [IDX_W-1:0]     rdCell
);

  localparam logic [IDX_W-1:0] LAST_CELL = IDX_W'(NUM_CELLS - 1);
  localparam logic [IDX_W-1:0] RING_SIZE = IDX_W'(NUM_CELLS);

  logic             fullQ;
  logic [IDX_W-1:0] ofsQ;
  logic [IDX_W-1:0] startCell;
  logic [IDX_W-1:0] ofsMod;

  function automatic logic [IDX_W-1:0] stepFwd(input logic [IDX_W-1:0] x);
    return (x == LAST_CELL) ? '0 : x + 1'b1;
  endfunction

  assign ofsMod = IDX_W'(int'(winOffset) % NUM_CELLS);

  always_comb begin
    if (fullQ) begin
      startCell = stepFwd(trigCell);
    end else if (trigCell >= ofsQ) begin
      startCell = trigCell - ofsQ;
    end else begin
      startCell = trigCell + RING_SIZE - ofsQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writePos <= '0;
      trigCell <= '0;
      rdCell   <= '0;
      fullQ    <= 1'b0;
      ofsQ     <= '0;
    end else begin
      if (strobe.advWrite) writePos <= stepFwd(writePos);
      if (strobe.loadTrig) begin
        trigCell <= writePos;
        fullQ    <= fullMode;
        ofsQ     <= ofsMod;
      end
      if (strobe.loadStart)    rdCell <= startCell;
      else if (strobe.advRead) rdCell <= stepFwd(rdCell);
    end
  end

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_wen
    assign writeEn[c] = sampling && (writePos == IDX_W'(c));
  end

endmodule

// File: rtl/ccm_control.sv
module ccm_control
  import ccm_pkg::*;
#(
  parameter int NUM_CELLS = 16,
  parameter int CNT_W     = $clog2(NUM_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armIn,
  input  logic             sampleTick,
  input  logic             trigIn,
  input  logic             fullMode,
  input  logic [CNT_W-1:0] winLength,
  input  logic             readAck,
  output dp_strobe_t       strobe,
  output ctrl_state_e      state,
  output logic             rdValid,
  output logic             doneOut
);

  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(NUM_CELLS);

  ctrl_state_e      stateNxt;
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] lenEff;
  logic             lastCell;

  always_comb begin
    if (fullMode || winLength > FULL_LEN) lenEff = FULL_LEN;
    else if (winLength == '0)             lenEff = CNT_W'(1);
    else                                  lenEff = winLength;
  end

  assign rdValid  = (state == ST_READOUT);
  assign doneOut  = (state == ST_REARM);
  assign lastCell = (remaining == CNT_W'(1));

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE:     if (armIn) stateNxt = ST_SAMPLING;
      ST_SAMPLING: begin
        if (trigIn) begin
          strobe.loadTrig = 1'b1;
          stateNxt        = ST_FROZEN;
        end else begin
          strobe.advWrite = sampleTick;
        end
      end
      ST_FROZEN: begin
        strobe.loadStart = 1'b1;
        stateNxt         = ST_READOUT;
      end
      ST_READOUT: begin
        if (readAck) begin
          if (lastCell) stateNxt = ST_REARM;
          else          strobe.advRead = 1'b1;
        end
      end
      ST_REARM:    stateNxt = ST_SAMPLING;
      default:     stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
    end else begin
      state <= stateNxt;
      if (strobe.loadTrig)     remaining <= lenEff;
      else if (strobe.advRead) remaining <= remaining - 1'b1;
    end
  end

endmodule

// File: rtl/circ_capture_ctrl.sv
module circ_capture_ctrl
  import ccm_pkg::*;
#(
  parameter  int NUM_CELLS = 16,
  localparam int IDX_W     = $clog2(NUM_CELLS),
  localparam int CNT_W     = $clog2(NUM_CELLS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 armIn,
  input  logic                 sampleTick,
  input  logic                 trigIn,
  input  logic                 fullMode,
  input  logic [IDX_W-1:0]     winOffset,
  input  logic [CNT_W-1:0]     winLength,
  input  logic                 readAck,
  output logic [NUM_CELLS-1:0] writeEn,
  output logic                 rdValid,
  output logic [IDX_W-1:0]     rdCell,
  output logic [IDX_W-1:0]     trigCell,
  output logic                 doneOut
);

  dp_strobe_t  strobe;
  ctrl_state_e curState;
  logic [IDX_W-1:0] curWrite;

  ccm_control #(.NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .armIn      (armIn),
    .sampleTick (sampleTick),
    .trigIn     (trigIn),
    .fullMode   (fullMode),
    .winLength  (winLength),
    .readAck    (readAck),
    .strobe     (strobe),
    .state      (curState),
    .rdValid    (rdValid),
    .doneOut    (doneOut)
  );

  ccm_datapath #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampling  (curState == ST_SAMPLING),
    .fullMode  (fullMode),
    .winOffset (winOffset),
    .writeEn   (writeEn),
    .writePos  (curWrite),
    .trigCell  (trigCell),
    .rdCell    (rdCell)
  );

endmodule

// File: rtl/circ_capture_ctrl_chk.sv
module circ_capture_ctrl_chk
  import ccm_pkg::*;
#(
  parameter int NUM_CELLS = 16,
  parameter int IDX_W     = $clog2(NUM_CELLS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 trigIn,
  input logic                 readAck,
  input logic [NUM_CELLS-1:0] writeEn,
  input logic                 rdValid,
  input logic [IDX_W-1:0]     rdCell,
  input logic [IDX_W-1:0]     trigCell,
  input logic                 doneOut,
  input ctrl_state_e          curState,
  input logic [IDX_W-1:0]     curWrite
);

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] x);
    return (x == IDX_W'(NUM_CELLS - 1)) ? '0 : x + 1'b1;
  endfunction

  // R2: never more than one cell enabled
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(writeEn));

  // R4: an accepted trigger freezes writing and keeps the active cell
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_SAMPLING && trigIn) |=>
      (writeEn == '0 && trigCell == $past(curWrite)));

  // R5: trigger outside sampling leaves the stored cell alone
  a_r5_ignore_trig: assert property (@(posedge clk) disable iff (!rstN)
    (curState != ST_SAMPLING && trigIn) |=> $stable(trigCell));

  // R8: an unacknowledged cell is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !readAck) |=> (rdValid && $stable(rdCell)));

  // R8: an acknowledged cell is followed by its neighbour or by the end
  a_r8_advance: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && readAck) |=> (!rdValid || rdCell == nextIdx($past(rdCell))));

  // R9: done is a single-cycle pulse that follows the last acknowledge
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOut) |-> $past(rdValid && readAck));

endmodule

bind circ_capture_ctrl circ_capture_ctrl_chk #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .trigIn   (trigIn),
  .readAck  (readAck),
  .writeEn  (writeEn),
  .rdValid  (rdValid),
  .rdCell   (rdCell),
  .trigCell (trigCell),
  .doneOut  (doneOut),
  .curState (curState),
  .curWrite (curWrite)
);

// File: tb/circ_capture_ctrl_bench.sv
module circ_capture_ctrl_bench;

  localparam int N     = 12;
  localparam int IDX_W = $clog2(N);
  localparam int CNT_W = $clog2(N + 1);
  localparam int WATCHDOG = 20000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             armIn = 1'b0;
  logic             sampleTick = 1'b0;
  logic             trigIn = 1'b0;
  logic             fullMode = 1'b0;
  logic [IDX_W-1:0] winOffset = '0;
  logic [CNT_W-1:0] winLength = '0;
  logic             readAck = 1'b0;
  logic [N-1:0]     writeEn;
  logic             rdValid;
  logic [IDX_W-1:0] rdCell;
  logic [IDX_W-1:0] trigCell;
  logic             doneOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int modelPos = 0;
  int expQ[$];
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  circ_capture_ctrl #(.NUM_CELLS(N)) u_circ_capture_ctrl (
    .clk(clk), .rstN(rstN), .armIn(armIn), .sampleTick(sampleTick),
    .trigIn(trigIn), .fullMode(fullMode), .winOffset(winOffset),
    .winLength(winLength), .readAck(readAck), .writeEn(writeEn),
    .rdValid(rdValid), .rdCell(rdCell), .trigCell(trigCell), .doneOut(doneOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: consumes read cells with occasional stalls
  initial begin : monitor
    bit checked = 1'b0;
    int lastCell = 0;
    int ackCnt = 0;
    forever begin
      @(negedge clk);
      if (readAck) begin
        readAck = 1'b0;
        checked = 1'b0;
      end
      if (rdValid && !checked) begin
        if (expQ.size() == 0) begin
          chk("R8 unexpected cell", int'(rdCell), -1);
        end else begin
          chk("R6/R7 read cell", int'(rdCell), expQ.pop_front());
        end
        lastCell = int'(rdCell);
        checked = 1'b1;
      end else if (rdValid && checked) begin
        chk("R8 cell held", int'(rdCell), lastCell);
        ackCnt++;
        if (ackCnt % 3 != 1) readAck = 1'b1;
      end
    end
  end

  task automatic capture(input int ticks, input bit full, input int ofs,
                         input int len, input bit tickWithTrig);
    int start;
    int n;
    int waitCnt;
    repeat (ticks) begin
      sampleTick = 1'b1;
      @(negedge clk);
    end
    sampleTick = 1'b0;
    modelPos = (modelPos + ticks) % N;
    chk("R3 write position", int'(writeEn), 1 << modelPos);
    if (full) begin
      start = (modelPos + 1) % N;
      n = N;
    end else begin
      start = (modelPos - (ofs % N) + N) % N;
      n = (len == 0) ? 1 : ((len > N) ? N : len);
    end
    for (int i = 0; i < n; i++) expQ.push_back((start + i) % N);
    trigIn = 1'b1;
    sampleTick = tickWithTrig;
    fullMode = full;
    winOffset = IDX_W'(ofs);
    winLength = CNT_W'(len);
    @(negedge clk);
    trigIn = 1'b0;
    sampleTick = 1'b0;
    fullMode = ~full;          // later changes must not matter (R6)
    winOffset = IDX_W'(ofs + 5);
    winLength = CNT_W'(len + 3);
    chk("R4 trigger cell", int'(trigCell), modelPos);
    chk("R4 writing stopped", int'(writeEn), 0);
    chk("R8 valid not yet", int'(rdValid), 0);
    @(negedge clk);
    chk("R8 valid second cycle", int'(rdValid), 1);
    if (n >= 4) begin
      trigIn = 1'b1;
      sampleTick = 1'b1;
      @(negedge clk);
      trigIn = 1'b0;
      sampleTick = 1'b0;
      chk("R5 trigger ignored", int'(trigCell), modelPos);
      chk("R4 no write during readout", int'(writeEn), 0);
    end
    waitCnt = 0;
    while (!doneOut && waitCnt < 500) begin
      @(negedge clk);
      waitCnt++;
    end
    chk("R9 done seen", int'(doneOut), 1);
    chk("R9 all cells read", expQ.size(), 0);
    chk("R9 valid low at done", int'(rdValid), 0);
    expQ.delete();
    @(negedge clk);
    chk("R9 done one cycle", int'(doneOut), 0);
    chk("R9 resume at trigger cell", int'(writeEn), 1 << modelPos);
  endtask

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 writeEn", int'(writeEn), 0);
    chk("R1 rdValid", int'(rdValid), 0);
    chk("R1 doneOut", int'(doneOut), 0);
    chk("R1 trigCell", int'(trigCell), 0);

    trigIn = 1'b1;
    sampleTick = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
    sampleTick = 1'b0;
    @(negedge clk);
    chk("R5 idle trigger", int'(trigCell), 0);
    chk("R5 idle no readout", int'(rdValid), 0);
    chk("R2 idle no write", int'(writeEn), 0);

    armIn = 1'b1;
    @(negedge clk);
    armIn = 1'b0;
    chk("R2 armed at cell 0", int'(writeEn), 1);

    capture(5, 1'b0, 3, 4, 1'b0);    // R6 plain window
    capture(8, 1'b0, 3, 5, 1'b0);    // R3/R6 wrap across cell 11
    capture(3, 1'b1, 7, 2, 1'b0);    // R7 full ring
    capture(2, 1'b0, 14, 0, 1'b1);   // R6 offset mod N, length 0, R4 priority
    capture(11, 1'b0, 0, 15, 1'b0);  // R6 length clamp

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule